// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block sits between three timer/counters and a CPU core. Each timer reports events as single-cycle pulses: overflow, compare match and, for timer 1, input capture. The block latches each pulse into a sticky flag bit and holds a mask register that mirrors the flag layout bit for bit. Flags that are set, unmasked and covered by the global interrupt enable become pending requests. The highest-numbered pending request is offered to the CPU as a vector index with a valid strobe. When the CPU acknowledges it, only that flag is cleared.

Both registers sit on a single-cycle register bus in an 8-bit I/O space. Reads return data combinationally in the cycle the read strobe is high. Writes take effect at the next clock edge. Software clears a flag by writing a one to its bit. When timer 1 runs in PWM mode, its overflow flag takes its set event from the counter leaving zero, not from a normal overflow.

Top module: `tif_ctrl`

## Requirements
- R1: After reset, the flag register and the mask register both read 0x00 and `irq_valid` is low.
- R2: A pulse on an event input sets its flag at the next clock edge, and the flag then reads back at I/O address 0x38. Flag bits: 7 timer1 overflow, 6 timer1 compare A, 5 timer1 compare B, 4 timer2 overflow, 3 timer1 capture, 2 timer2 compare, 1 timer0 overflow, 0 timer0 compare. `evt_pulse[k]` drives flag bit k for k = 0..6.
- R3: A bus write to 0x38 clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: The mask register sits at I/O address 0x39, and a write loads all eight bits. Mask bit k enables flag bit k.
- R5: `irq_valid` is high exactly when some bit is 1 in flag, mask and `gie` together.
- R6: While `irq_valid` is high, `irq_index` equals the highest bit position that is pending.
- R7: A cycle with `irq_ack` and `irq_valid` both high clears only the flag at `irq_index`.
- R8: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R9: While `t1_pwm_mode` is 1, flag 7 sets only on `t1_leave_zero_evt` and ignores `t1_ovf_evt`. While it is 0, flag 7 sets only on `t1_ovf_evt` and ignores `t1_leave_zero_evt`.
- R10: A read at any other address returns 0x00, and a write at any other address changes neither register. Reads with `bus_rd` low also return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | I/O register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| gie | input | 1 | Global interrupt enable |
| evt_pulse | input | 7 | Event pulses for flag bits 6..0 |
| t1_ovf_evt | input | 1 | Timer 1 overflow pulse |
| t1_leave_zero_evt | input | 1 | Timer 1 counter leaving zero pulse |
| t1_pwm_mode | input | 1 | Timer 1 is in PWM mode |
| irq_valid | output | 1 | A request is pending |
| irq_index | output | 3 | Vector index of the request offered |
| irq_ack | input | 1 | CPU acknowledge of the offered request |

## Verification
Read data, `irq_valid` and `irq_index` are combinational functions of the stored registers and the current inputs. The bench drives inputs on the falling edge and compares these outputs one time step later, in the same cycle, against a model that holds the flags and the mask. The effect of an event, a write or an acknowledge shows up one clock edge later. So the model updates its registers only at the rising edge, using the inputs that were present then, and the following cycle's read checks the result. Directed cases cover clear-versus-set collisions, mode changes and masking, and a seeded random phase follows them.

// File: rtl/tif_pkg.sv
package tif_pkg;
   localparam int TIF_NUM_SRC = 8;
   localparam int TIF_IDX_W   = $clog2(TIF_NUM_SRC);

   // flag bit positions: priority and vector index follow them
   localparam int TIF_BIT_T0_CMP  = 0;
   localparam int TIF_BIT_T0_OVF  = 1;
   localparam int TIF_BIT_T2_CMP  = 2;
   localparam int TIF_BIT_T1_CAP  = 3;
   localparam int TIF_BIT_T2_OVF  = 4;
   localparam int TIF_BIT_T1_CMPB = 5;
   localparam int TIF_BIT_T1_CMPA = 6;
   localparam int TIF_BIT_T1_OVF  = 7;
endpackage

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("tif_flag_bank: N must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_o[gi] <= 1'b0;
            else if (set_i[gi])
               flag_o[gi] <= 1'b1;
            else if (clr_i[gi])
               flag_o[gi] <= 1'b0;
         end

         assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[gi] |=> flag_o[gi]);
         assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[gi] && !set_i[gi]) |=> !flag_o[gi]);
         assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[gi] && !set_i[gi]) |=> $stable(flag_o[gi]));
      end
   endgenerate
endmodule

// File: rtl/tif_mask_reg.sv
module tif_mask_reg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_o <= '0;
      else if (wr_en)
         mask_o <= wdata;
   end

   assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_o == $past(wdata)));
   assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask_o));
endmodule

// File: rtl/tif_prio_arb.sv
module tif_prio_arb #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     grant_o
);
   generate
      if ((1 << IDX_W) < N) begin : g_bad_idx
         $error("tif_prio_arb: IDX_W too narrow for N");
      end
   endgenerate

   // higher positions overwrite lower ones: the top set bit wins
   always_comb begin
      idx_o   = '0;
      grant_o = '0;
      for (int k = 0; k < N; k++) begin
         if (req_i[k]) begin
            idx_o   = IDX_W'(k);
            grant_o = N'(1) << k;
         end
      end
   end

   assign valid_o = |req_i;

   always_comb begin
      assert_grant_onehot_R6: assert ($onehot0(grant_o));
   end
endmodule

// File: rtl/tif_ctrl.sv
module tif_ctrl #(
   parameter int                 NUM_SRC   = tif_pkg::TIF_NUM_SRC,
   parameter int                 ADDR_W    = 8,
   parameter int                 DATA_W    = 8,
   parameter logic [ADDR_W-1:0]  FLAG_ADDR = 8'h38,
   parameter logic [ADDR_W-1:0]  MASK_ADDR = 8'h39,
   parameter bit                 HAS_PWM   = 1'b1,
   localparam int                IDX_W     = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              gie,
   input  logic [NUM_SRC-2:0] evt_pulse,
   input  logic              t1_ovf_evt,
   input  logic              t1_leave_zero_evt,
   input  logic              t1_pwm_mode,
   output logic              irq_valid,
   output logic [IDX_W-1:0]  irq_index,
   input  logic              irq_ack
);
   localparam int TOP_BIT = NUM_SRC - 1;

   generate
      if (NUM_SRC != DATA_W) begin : g_bad_width
         $error("tif_ctrl: NUM_SRC must equal DATA_W");
      end
      if (FLAG_ADDR == MASK_ADDR) begin : g_bad_addr
         $error("tif_ctrl: flag and mask addresses collide");
      end
   endgenerate

   logic              hit_flag, hit_mask;
   logic [NUM_SRC-1:0] set_vec, clr_vec, flags, mask, pending, grant;
   logic              t1_top_set;

   assign hit_flag = (bus_addr == FLAG_ADDR);
   assign hit_mask = (bus_addr == MASK_ADDR);

   generate
      if (HAS_PWM) begin : g_pwm_sel
         assign t1_top_set = t1_pwm_mode ? t1_leave_zero_evt : t1_ovf_evt;
      end else begin : g_no_pwm
         assign t1_top_set = t1_ovf_evt;
      end
   endgenerate

   assign set_vec = {t1_top_set, evt_pulse};
   assign clr_vec = ((bus_wr && hit_flag) ? bus_wdata : '0)
                  | (irq_ack ? grant : '0);

   tif_flag_bank #(.N(NUM_SRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flag_o (flags)
   );

   tif_mask_reg #(.N(NUM_SRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr && hit_mask),
      .wdata  (bus_wdata),
      .mask_o (mask)
   );

   assign pending = flags & mask & {NUM_SRC{gie}};

   tif_prio_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .req_i   (pending),
      .valid_o (irq_valid),
      .idx_o   (irq_index),
      .grant_o (grant)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (hit_flag)      bus_rdata = flags;
         else if (hit_mask) bus_rdata = mask;
      end
   end

   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (gie && flags[irq_index] && mask[irq_index]));
   assert_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_valid);
   assert_highest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ((flags & mask) >> irq_index) == NUM_SRC'(1));
   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_ack && !set_vec[irq_index]) |=> !flags[$past(irq_index)]);
   assert_pwm_ignores_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_pwm_mode && !t1_leave_zero_evt && !flags[TOP_BIT]) |=> !flags[TOP_BIT]);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (flags == '0 && mask == '0));
endmodule

// File: tb/tif_ctrl_tb.sv
`timescale 1ns/1ps
module tif_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_addr, bus_wdata, bus_rdata;
   logic       bus_wr, bus_rd, gie, t1_ovf_evt, t1_leave_zero_evt, t1_pwm_mode;
   logic [6:0] evt_pulse;
   logic       irq_valid, irq_ack;
   logic [2:0] irq_index;

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] m_flag, m_mask;

   always #10 clk = ~clk;

   tif_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gie(gie), .evt_pulse(evt_pulse), .t1_ovf_evt(t1_ovf_evt),
      .t1_leave_zero_evt(t1_leave_zero_evt), .t1_pwm_mode(t1_pwm_mode),
      .irq_valid(irq_valid), .irq_index(irq_index), .irq_ack(irq_ack)
   );

   function automatic logic [7:0] f_setv(logic [6:0] ev, logic ovf, logic lz, logic pwm);
      return {(pwm ? lz : ovf), ev};
   endfunction

   function automatic int f_top(logic [7:0] p);
      int r = -1;
      for (int i = 0; i < 8; i++) if (p[i]) r = i;
      return r;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      bus_addr = 8'h00; bus_wr = 0; bus_rd = 0; bus_wdata = 8'h00;
      evt_pulse = '0; t1_ovf_evt = 0; t1_leave_zero_evt = 0; irq_ack = 0;
   endtask

   // inputs already driven; check this cycle, then advance the model at the edge
   task automatic cycle();
      logic [7:0] pend, clr, rexp;
      int top;
      #1;
      pend = m_flag & m_mask & {8{gie}};
      top  = f_top(pend);
      chk("R5 irq_valid", {7'b0, irq_valid}, {7'b0, (pend != 8'h00)});
      if (pend != 8'h00) chk("R6 irq_index", {5'b0, irq_index}, 8'(top));
      rexp = !bus_rd ? 8'h00 : (bus_addr == 8'h38) ? m_flag :
             (bus_addr == 8'h39) ? m_mask : 8'h00;
      chk("R2 R4 R10 read data", bus_rdata, rexp);
      @(posedge clk);
      clr = (bus_wr && bus_addr == 8'h38) ? bus_wdata : 8'h00;
      if (irq_ack && pend != 8'h00) clr[top] = 1'b1;
      m_flag = f_setv(evt_pulse, t1_ovf_evt, t1_leave_zero_evt, t1_pwm_mode) | (m_flag & ~clr);
      if (bus_wr && bus_addr == 8'h39) m_mask = bus_wdata;
      @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      idle(); bus_wr = 1; bus_addr = a; bus_wdata = d; cycle(); idle();
   endtask

   task automatic rd_exp(logic [7:0] a, logic [7:0] exp, string tag);
      idle(); bus_rd = 1; bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
      cycle(); idle();
   endtask

   task automatic pulse(logic [6:0] ev, logic ovf, logic lz);
      idle(); evt_pulse = ev; t1_ovf_evt = ovf; t1_leave_zero_evt = lz; cycle(); idle();
   endtask

   initial begin
      #(20ns * 150000);
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed = 1234;
      void'($urandom(seed));
      idle(); gie = 0; t1_pwm_mode = 0; rst_n = 0;
      m_flag = 8'h00; m_mask = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      #1 chk("R1 irq_valid after reset", {7'b0, irq_valid}, 8'h00);
      rd_exp(8'h38, 8'h00, "R1 flags after reset");
      rd_exp(8'h39, 8'h00, "R1 mask after reset");

      // R2 events set flags
      pulse(7'b0001000, 0, 0);
      rd_exp(8'h38, 8'h08, "R2 capture flag bit3");
      pulse(7'b1000000, 0, 0);
      rd_exp(8'h38, 8'h48, "R2 compare A flag bit6");

      // R3 write-one clear, zero keeps
      wr(8'h38, 8'h00);
      rd_exp(8'h38, 8'h48, "R3 zero write keeps flags");
      wr(8'h38, 8'h08);
      rd_exp(8'h38, 8'h40, "R3 one clears bit3 only");
      wr(8'h38, 8'h40);
      rd_exp(8'h38, 8'h00, "R3 one clears bit6");

      // R4 mask
      wr(8'h39, 8'hA5);
      rd_exp(8'h39, 8'hA5, "R4 mask readback");

      // R10 other address
      pulse(7'b0000100, 0, 0);
      wr(8'h3A, 8'hFF);
      rd_exp(8'h38, 8'h04, "R10 flags untouched");
      rd_exp(8'h39, 8'hA5, "R10 mask untouched");
      rd_exp(8'h3A, 8'h00, "R10 unmapped read");
      wr(8'h38, 8'h04);

      // R9 PWM selection for flag 7
      t1_pwm_mode = 1;
      pulse('0, 1, 0);
      rd_exp(8'h38, 8'h00, "R9 pwm ignores overflow");
      pulse('0, 0, 1);
      rd_exp(8'h38, 8'h80, "R9 pwm sets on leaving zero");
      wr(8'h38, 8'h80);
      t1_pwm_mode = 0;
      pulse('0, 0, 1);
      rd_exp(8'h38, 8'h00, "R9 normal ignores leaving zero");
      pulse('0, 1, 0);
      rd_exp(8'h38, 8'h80, "R9 normal sets on overflow");
      wr(8'h38, 8'h80);

      // R5 R6 R7 gating, priority, acknowledge
      wr(8'h39, 8'hFF);
      pulse(7'b1000001, 0, 0);
      #1 chk("R5 gie low blocks request", {7'b0, irq_valid}, 8'h00);
      gie = 1;
      #1 chk("R5 request with gie", {7'b0, irq_valid}, 8'h01);
      chk("R6 highest index", {5'b0, irq_index}, 8'h06);
      idle(); irq_ack = 1; cycle(); idle();
      rd_exp(8'h38, 8'h01, "R7 ack clears offered flag only");
      #1 chk("R6 next index", {5'b0, irq_index}, 8'h00);

      // R8 set beats clear
      idle(); irq_ack = 1; evt_pulse = 7'b0000001; cycle(); idle();
      rd_exp(8'h38, 8'h01, "R8 set beats ack");
      idle(); bus_wr = 1; bus_addr = 8'h38; bus_wdata = 8'h01; evt_pulse = 7'b0000001; cycle(); idle();
      rd_exp(8'h38, 8'h01, "R8 set beats write-one");
      wr(8'h38, 8'h01);
      rd_exp(8'h38, 8'h00, "R3 final clear");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int sel;
         idle();
         sel = int'($urandom_range(0, 3));
         bus_addr   = (sel == 0) ? 8'h38 : (sel == 1) ? 8'h39 : (sel == 2) ? 8'h3A : 8'(($urandom));
         bus_wr     = ($urandom_range(0, 5) == 0);
         bus_rd     = ($urandom_range(0, 1) == 0);
         bus_wdata  = 8'($urandom);
         evt_pulse  = 7'($urandom) & 7'($urandom) & 7'($urandom);
         t1_ovf_evt = ($urandom_range(0, 7) == 0);
         t1_leave_zero_evt = ($urandom_range(0, 7) == 0);
         irq_ack    = ($urandom_range(0, 2) == 0);
         if (n % 200 == 0) t1_pwm_mode = ~t1_pwm_mode;
         gie        = ($urandom_range(0, 9) != 0);
         cycle();
      end

      idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule